// File: doc/BRIEF.md
# Dual Glitch-Free Clock Request Gate

This block sits between a free-running source clock and two peripheral clock loads. Each load has its own active-high request line. While a request is high, and the shared supply is up, the matching output carries the source clock. Lane A carries the clock in true polarity. Lane B carries it inverted. Each lane captures its enable on the edge that leaves its own output low. A lane therefore starts and stops only during a low phase of its output, and it never emits a shortened pulse.

A small sequencer in a separate, always-running reference clock domain drives a supply-enable output. This output is high while either synchronized request is high and no overtemperature is flagged. When the supply enable rises, a turn-on delay counter runs for a parameterised number of reference cycles and then raises supply-ready. No lane may open before supply-ready is high. If both requests drop, or overtemperature is raised, the supply shuts off and both lanes close at their next safe edge. The default delay of 12500 cycles at a 50 MHz reference gives 250 µs. That lies inside the 200 to 350 µs window that the supply needs.

Top module: `dual_req_clock_gate`

## Requirements
- R1: While reset is asserted and right after it, supply_en, supply_ready, gclk_a and gclk_b are all low.
- R2: From the all-off state, the first request rising makes supply_en high after exactly SYNC_STAGES+1 reference clock edges, provided overtemp is low.
- R3: supply_ready rises exactly READY_CYCLES reference edges after supply_en rises, and never earlier.
- R4: While supply_ready is low, neither gated output shows a rising edge, even with both requests high.
- R5: With req_a high and the supply ready, gclk_a equals src_clk (high in the src high phase, low in the src low phase). With req_a low, gclk_a stays low.
- R6: With req_b high and the supply ready, gclk_b equals the inverse of src_clk (high in the src low phase, low in the src high phase). With req_b low, gclk_b stays low.
- R7: Every high pulse on gclk_a and on gclk_b lasts one full half period of src_clk, whenever the requests toggle.
- R8: When both requests have been low for SYNC_STAGES+1 reference edges, supply_en is low on the next edge, and supply_ready and both outputs go low.
- R9: When overtemp has been high for SYNC_STAGES+1 reference edges, the supply is off and both outputs are held low, whatever the requests. Once overtemp clears with a request still high, the supply ramps up again.
- R10: The two lanes are independent. Each request affects only its own output.
- R11: supply_ready is never high while supply_en is low, and it is low in the cycle where supply_en rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ref_clk | input | 1 | Free-running reference clock for the supply sequencer |
| src_clk | input | 1 | Source clock to be distributed |
| req_a | input | 1 | Clock request for lane A, active high |
| req_b | input | 1 | Clock request for lane B, active high |
| overtemp | input | 1 | Overtemperature flag, forces the supply off while high |
| supply_en | output | 1 | Enable for the shared supply |
| supply_ready | output | 1 | Supply considered settled after the turn-on delay |
| gclk_a | output | 1 | Gated source clock, true polarity |
| gclk_b | output | 1 | Gated source clock, inverted polarity |

## Verification
The bench builds the block with READY_CYCLES set to 40 and SYNC_STAGES left at 2. This shortens the turn-on delay enough to pass through it many times: once for each table vector, once after each overtemperature event, and once in an exact edge-count measurement of both the supply-enable latency and the ready latency. The 38 ns source period does not divide the 20 ns reference period. Request changes and ready changes therefore fall at many different source phases, and each of them is checked by measuring the width of every output pulse.

// File: rtl/dqg_pkg.sv
`timescale 1ns/1ps
package dqg_pkg;
  localparam int NUM_LANES = 2;

  typedef enum logic [1:0] {
    SUP_OFF  = 2'd0,
    SUP_RAMP = 2'd1,
    SUP_ON   = 2'd2
  } sup_state_t;
endpackage

// File: rtl/dqg_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer; also used as a reset release stage.
module dqg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= {STAGES{RST_VAL}};
    end else begin
      shift_q <= shift_d;
    end
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/dqg_supply_seq.sv
`timescale 1ns/1ps
// Supply enable and turn-on delay sequencer, reference clock domain.
module dqg_supply_seq
  import dqg_pkg::*;
#(
  parameter int READY_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic hot,
  output logic supply_en,
  output logic supply_ready
);
  localparam int CW = (READY_CYCLES > 1) ? $clog2(READY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(READY_CYCLES - 1);

  sup_state_t     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    unique case (st_q)
      SUP_OFF: begin
        if (any_req && !hot) begin
          st_d   = SUP_RAMP;
          cnt_en = 1'b1;
          cnt_d  = '0;
        end
      end
      SUP_RAMP: begin
        if (!any_req || hot) begin
          st_d = SUP_OFF;
        end else if (cnt_q == LAST) begin
          st_d = SUP_ON;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      SUP_ON: begin
        if (!any_req || hot) begin
          st_d = SUP_OFF;
        end
      end
      default: st_d = SUP_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SUP_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign supply_en    = (st_q != SUP_OFF);
  assign supply_ready = (st_q == SUP_ON);
endmodule

// File: rtl/dqg_gate_lane.sv
`timescale 1ns/1ps
// One gated output. The enable is captured on the edge at which the
// output phase is low, so the AND gate only opens or closes while low.
module dqg_gate_lane #(
  parameter bit CAPTURE_RISE = 1'b0,
  parameter bit INVERT_OUT   = 1'b0
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic req,
  input  logic ready,
  output logic gclk
);
  logic en_d;
  logic en_q;
  logic phase;

  always_comb begin
    en_d = req & ready;
  end

  generate
    if (CAPTURE_RISE) begin : g_rise
      always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= 1'b0;
        end else begin
          en_q <= en_d;
        end
      end
    end else begin : g_fall
      always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= 1'b0;
        end else begin
          en_q <= en_d;
        end
      end
    end
  endgenerate

  generate
    if (INVERT_OUT) begin : g_inv
      assign phase = ~src_clk;
    end else begin : g_true
      assign phase = src_clk;
    end
  endgenerate

  assign gclk = phase & en_q;
endmodule

// File: rtl/dual_req_clock_gate.sv
`timescale 1ns/1ps
module dual_req_clock_gate
  import dqg_pkg::*;
#(
  parameter int READY_CYCLES = 12500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic rst_n,
  input  logic ref_clk,
  input  logic src_clk,
  input  logic req_a,
  input  logic req_b,
  input  logic overtemp,
  output logic supply_en,
  output logic supply_ready,
  output logic gclk_a,
  output logic gclk_b
);
  localparam int NUM_SYNC_IN = NUM_LANES + 1;

  logic                   ref_rst_n;
  logic                   src_rst_n;
  logic [NUM_SYNC_IN-1:0] raw_in;
  logic [NUM_SYNC_IN-1:0] sync_in;
  logic [NUM_LANES-1:0]   lane_req;
  logic [NUM_LANES-1:0]   lane_out;
  logic                   any_req_s;
  logic                   ready_src;

  // Reset release stages, one per clock domain.
  dqg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n)
  );
  dqg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_src_rst (
    .clk(src_clk), .rst_n(rst_n), .d(1'b1), .q(src_rst_n)
  );

  // Requests and the overtemperature flag enter the reference domain.
  assign raw_in = {overtemp, req_b, req_a};

  generate
    for (genvar s = 0; s < NUM_SYNC_IN; s++) begin : g_in_sync
      dqg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk(ref_clk), .rst_n(ref_rst_n), .d(raw_in[s]), .q(sync_in[s])
      );
    end
  endgenerate

  assign any_req_s = |sync_in[NUM_LANES-1:0];

  dqg_supply_seq #(.READY_CYCLES(READY_CYCLES)) u_seq (
    .clk          (ref_clk),
    .rst_n        (ref_rst_n),
    .any_req      (any_req_s),
    .hot          (sync_in[NUM_LANES]),
    .supply_en    (supply_en),
    .supply_ready (supply_ready)
  );

  // Ready level moved into the source clock domain.
  dqg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_ready_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(supply_ready), .q(ready_src)
  );

  assign lane_req = {req_b, req_a};

  // Lane 0: true polarity, falling capture. Lane 1: inverted, rising capture.
  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      dqg_gate_lane #(
        .CAPTURE_RISE(i == 1),
        .INVERT_OUT  (i == 1)
      ) u_lane (
        .src_clk (src_clk),
        .rst_n   (src_rst_n),
        .req     (lane_req[i]),
        .ready   (ready_src),
        .gclk    (lane_out[i])
      );
    end
  endgenerate

  assign gclk_a = lane_out[0];
  assign gclk_b = lane_out[1];
endmodule

// File: rtl/dqg_chk.sv
`timescale 1ns/1ps
module dqg_chk #(
  parameter int READY_CYCLES = 12500,
  parameter int SYNC_STAGES  = 2
) (
  input logic rst_n,
  input logic ref_clk,
  input logic req_a,
  input logic req_b,
  input logic overtemp,
  input logic supply_en,
  input logic supply_ready
);
  localparam int QUIET = SYNC_STAGES + 1;
  localparam int QW    = $clog2(QUIET + 1);
  localparam int OW    = $clog2(READY_CYCLES + 1);

  logic [QW-1:0] idle_cnt;
  logic [QW-1:0] hot_cnt;
  logic [OW-1:0] on_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      hot_cnt  <= '0;
      on_cnt   <= '0;
    end else begin
      if (req_a || req_b)          idle_cnt <= '0;
      else if (idle_cnt < QW'(QUIET)) idle_cnt <= idle_cnt + 1'b1;
      if (!overtemp)               hot_cnt <= '0;
      else if (hot_cnt < QW'(QUIET))  hot_cnt <= hot_cnt + 1'b1;
      if (!supply_en)              on_cnt <= '0;
      else if (on_cnt < OW'(READY_CYCLES)) on_cnt <= on_cnt + 1'b1;
    end
  end

  // R8
  idle_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (idle_cnt >= QW'(QUIET)) |-> !supply_en);

  // R9
  hot_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (hot_cnt >= QW'(QUIET)) |-> !supply_en);

  // R3
  ready_delay_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    supply_ready |-> (on_cnt >= OW'(READY_CYCLES)));

  // R11
  ready_needs_en_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !supply_en |-> !supply_ready);

  // R11
  en_rise_not_ready_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(supply_en) |-> !supply_ready);
endmodule

bind dual_req_clock_gate dqg_chk #(
  .READY_CYCLES(READY_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .rst_n        (rst_n),
  .ref_clk      (ref_clk),
  .req_a        (req_a),
  .req_b        (req_b),
  .overtemp     (overtemp),
  .supply_en    (supply_en),
  .supply_ready (supply_ready)
);

// File: tb/sim_dual_req_clock_gate.sv
`timescale 1ns/1ps
module sim_dual_req_clock_gate;
  localparam int  READY_CYC = 40;
  localparam int  SYNC      = 2;
  localparam real REF_HALF  = 10.0;
  localparam real SRC_HALF  = 19.0;
  // {req_a, req_b, overtemp, exp_en, exp_ready, exp_a_on, exp_b_on}
  localparam logic [6:0] VEC [8] = '{
    7'b000_0000, 7'b100_1110, 7'b010_1101, 7'b110_1111,
    7'b111_0000, 7'b101_0000, 7'b110_1111, 7'b000_0000
  };

  logic rst_n, ref_clk, src_clk, req_a, req_b, overtemp;
  logic supply_en, supply_ready, gclk_a, gclk_b;
  int   n_checks, n_fails;
  int   a_rises, b_rises;
  bit   done;
  realtime ta, tb_t;
  bit   ta_ok, tb_ok;

  dual_req_clock_gate #(.READY_CYCLES(READY_CYC), .SYNC_STAGES(SYNC)) u0 (
    .rst_n(rst_n), .ref_clk(ref_clk), .src_clk(src_clk),
    .req_a(req_a), .req_b(req_b), .overtemp(overtemp),
    .supply_en(supply_en), .supply_ready(supply_ready),
    .gclk_a(gclk_a), .gclk_b(gclk_b)
  );

  initial begin ref_clk = 1'b0; forever #(REF_HALF) ref_clk = ~ref_clk; end
  initial begin src_clk = 1'b0; #3; forever #(SRC_HALF) src_clk = ~src_clk; end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // R7: pulse width monitor on both outputs
  always @(posedge gclk_a) begin ta = $realtime; ta_ok = 1'b1; a_rises++; end
  always @(negedge gclk_a) if (ta_ok) begin
    n_checks++;
    if (($realtime - ta) < SRC_HALF - 0.5 || ($realtime - ta) > SRC_HALF + 0.5) begin
      n_fails++;
      $display("FAIL R7 gclk_a pulse: actual %0.2f expected %0.2f", $realtime - ta, SRC_HALF);
    end
  end
  always @(posedge gclk_b) begin tb_t = $realtime; tb_ok = 1'b1; b_rises++; end
  always @(negedge gclk_b) if (tb_ok) begin
    n_checks++;
    if (($realtime - tb_t) < SRC_HALF - 0.5 || ($realtime - tb_t) > SRC_HALF + 0.5) begin
      n_fails++;
      $display("FAIL R7 gclk_b pulse: actual %0.2f expected %0.2f", $realtime - tb_t, SRC_HALF);
    end
  end

  // Check both phases of the source clock over a few periods.
  task automatic check_lanes(input string tag, input logic a_on, input logic b_on);
    for (int k = 0; k < 3; k++) begin
      @(posedge src_clk); #9;
      check({tag, " R5 a/high"}, gclk_a, a_on);
      check({tag, " R6 b/high"}, gclk_b, 1'b0);
      @(negedge src_clk); #9;
      check({tag, " R5 a/low"}, gclk_a, 1'b0);
      check({tag, " R6 b/low"}, gclk_b, b_on);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; a_rises = 0; b_rises = 0; done = 1'b0;
    ta_ok = 1'b0; tb_ok = 1'b0;
    rst_n = 1'b0; req_a = 1'b0; req_b = 1'b0; overtemp = 1'b0;
    settle(5);
    // R1: reset state
    check("R1 supply_en", supply_en, 1'b0);
    check("R1 supply_ready", supply_ready, 1'b0);
    check("R1 gclk_a", gclk_a, 1'b0);
    check("R1 gclk_b", gclk_b, 1'b0);
    rst_n = 1'b1;
    settle(4);
    check("R1 supply_en after release", supply_en, 1'b0);

    // Table walk: R5 R6 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      req_a = VEC[v][6]; req_b = VEC[v][5]; overtemp = VEC[v][4];
      settle(READY_CYC + 30);
      check($sformatf("vec%0d R8/R9 supply_en", v), supply_en, VEC[v][3]);
      check($sformatf("vec%0d R9/R11 supply_ready", v), supply_ready, VEC[v][2]);
      check_lanes($sformatf("vec%0d R10", v), VEC[v][1], VEC[v][0]);
      @(negedge ref_clk);
    end

    // R2 / R3: exact latencies from the off state
    begin
      int n_en, n_rdy;
      n_en = 0; n_rdy = 0;
      req_a = 1'b1;
      for (int e = 1; e <= READY_CYC + 10; e++) begin
        @(posedge ref_clk); #1;
        if (supply_en && n_en == 0) n_en = e;
        if (supply_ready && n_rdy == 0) n_rdy = e;
      end
      check($sformatf("R2 en latency %0d vs %0d", n_en, SYNC + 1), n_en == SYNC + 1, 1'b1);
      check($sformatf("R3 ready latency %0d vs %0d", n_rdy, SYNC + 1 + READY_CYC),
            n_rdy == SYNC + 1 + READY_CYC, 1'b1);
      req_a = 1'b0;
      settle(10);
      check("R8 supply_en off", supply_en, 1'b0);
      check("R8 supply_ready off", supply_ready, 1'b0);
      check_lanes("R8 quiet", 1'b0, 1'b0);
    end

    // R4: no edges while ramping
    begin
      int ra, rb;
      ra = a_rises; rb = b_rises;
      req_a = 1'b1; req_b = 1'b1;
      settle(READY_CYC);
      check("R4 still ramping", supply_ready, 1'b0);
      check($sformatf("R4 gclk_a rises %0d", a_rises - ra), a_rises == ra, 1'b1);
      check($sformatf("R4 gclk_b rises %0d", b_rises - rb), b_rises == rb, 1'b1);
      settle(20);
      check("R4 ready after ramp", supply_ready, 1'b1);
    end

    // R7: toggle each request at odd moments with the supply held on
    begin
      int ra;
      ra = a_rises;
      for (int k = 0; k < 12; k++) begin
        #(7 + 13 * k); req_a = ~req_a;
      end
      req_a = 1'b1;
      for (int k = 0; k < 12; k++) begin
        #(5 + 11 * k); req_b = ~req_b;
      end
      req_b = 1'b1;
      settle(6);
      check("R7 pulses seen", a_rises > ra, 1'b1);
      check_lanes("R7 after toggles", 1'b1, 1'b1);
    end

    // R9: overtemp while running, then restart
    overtemp = 1'b1;
    settle(SYNC + 2);
    check("R9 supply_en cut", supply_en, 1'b0);
    settle(6);
    check_lanes("R9 held low", 1'b0, 1'b0);
    overtemp = 1'b0;
    settle(READY_CYC + 20);
    check("R9 restart ready", supply_ready, 1'b1);
    check_lanes("R9 restart", 1'b1, 1'b1);

    req_a = 1'b0; req_b = 1'b0;
    settle(20);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule